// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block sits beside one processor core and walks it between full activity and three idle depths of rising power saving. An idle request arrives with a target depth. The core always stops at the shallowest idle level first and then steps deeper one level at a time. Level one stops the pipeline and gates the main clock group, and the caches keep answering snoops. Level two flushes the core caches through a handshake and then gates the remaining clocks. Level three saves the core context through a handshake and then switches the core supply off.

A wake event sends the core back to activity by undoing the same steps in reverse. From level three the supply is restored first, and a fixed settle interval is counted. The context is then restored, the remaining clocks return, and finally the pipeline is released. A wake that arrives during an entry handshake abandons the descent and unwinds only the steps already taken.

All control outputs, the level code and the busy flag are decoded from the registered sequencer state. Every response to an input therefore appears one clock after that input is sampled. The handshake inputs are plain level signals and are only looked at while the sequencer waits for them.

Top module: `idle_seq`

## Requirements
- R1: While reset is asserted and after its release, the block is active: every control output is low, `level` is 0 and `busy` is 0.
- R2: When active, a request with depth 1..3 and no wake makes `pipe_stop`, `clk_gate_main` and `snoop_en` rise on the next clock, with `level`=1. A request with depth 0 is ignored.
- R3: Going to depth 2 or deeper, `flush_req` is raised one cycle after level 1 is reached, and `snoop_en` stays high while it waits. `clk_gate_rest` rises and `snoop_en` falls one clock after `flush_done` is sampled, and not before.
- R4: Going to depth 3, `save_req` is raised one cycle after level 2 is reached. `pwr_off` rises one clock after `ctx_done` is sampled, and `level` becomes 3.
- R5: On a wake at level 3, `pwr_off` falls on the next clock. `restore_req` rises exactly SETTLE_CYC clocks later. One clock after `ctx_done` is sampled, `clk_gate_rest` falls while `pipe_stop` stays high. The block is active one clock after that.
- R6: A wake at level 1 makes the block active on the next clock. A wake at level 2 first gives one clock with the remaining clocks ungated, snoops enabled and the pipeline stopped (`level`=1), and the block is active on the clock after that.
- R7: A wake while `flush_req` is high drops all outputs to the active state on the next clock. A wake while `save_req` is high gives one clock of the level-1 unwind state (`save_req` low, `clk_gate_rest` low) and then the active state.
- R8: Wake beats a request in the same cycle. A request made during a transition is ignored. A request is also ignored when its depth is not deeper than the level the core is resting at. A deeper request at rest level 1 or 2 continues the descent on the next clock.
- R9: `level` encodes 0 = active, 1 = clocks partly gated (this includes the flush wait and the unwind step), 2 = all clocks gated (this includes the save wait), and 3 = power off (this includes the settle and restore phases). `busy` is 0 only when the core is active, at rest at its target level, or at level 3 with the supply off.
- R10: `flush_done` and `ctx_done` are ignored outside the phases that wait for them.
- R11: `snoop_en` is high exactly at level 1. It is never high while `clk_gate_rest` or `pwr_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_req | input | 1 | Idle request strobe |
| idle_depth | input | 2 | Requested idle depth, 0..3 |
| wake | input | 1 | Wake event |
| flush_done | input | 1 | Cache flush completed |
| ctx_done | input | 1 | Context save or restore completed |
| pipe_stop | output | 1 | Halt the core pipeline |
| clk_gate_main | output | 1 | Gate the main core clock group |
| clk_gate_rest | output | 1 | Gate the remaining core clocks |
| snoop_en | output | 1 | Caches service external snoops while halted |
| flush_req | output | 1 | Request a core cache flush |
| save_req | output | 1 | Request a context save |
| restore_req | output | 1 | Request a context restore |
| pwr_off | output | 1 | Open the core power gate (supply off) |
| level | output | 2 | Current idle level code |
| busy | output | 1 | Transition in progress |

## Verification
Every output is a pure decode of the state register. A wrong state, a wrong stored target or a skipped step therefore shows on the pins at the next negative clock edge after the edge that caused it. The only hidden quantity is the settle counter, which shows up as `restore_req` rising a clock too early or too late. A reference model kept in step with the block compares all outputs on every clock, so any divergence is flagged in the cycle where it happens.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [3:0] {
    ST_ACT     = 4'd0,
    ST_C1      = 4'd1,
    ST_FLUSH   = 4'd2,
    ST_C2      = 4'd3,
    ST_SAVE    = 4'd4,
    ST_C3      = 4'd5,
    ST_SETTLE  = 4'd6,
    ST_RESTORE = 4'd7,
    ST_UNGR    = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic pipe_stop;
    logic gate_main;
    logic gate_rest;
    logic snoop_en;
    logic flush_req;
    logic save_req;
    logic restore_req;
    logic pwr_off;
  } drive_t;

endpackage

// File: rtl/idle_seq_settle.sv
module idle_seq_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R5: the counter stays in range while the settle phase runs
  a_r5_settle_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));

endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import idle_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic [LVL_W-1:0] idle_depth,
  input  logic             wake,
  input  logic             flush_done,
  input  logic             ctx_done,
  input  logic             settle_done,
  output seq_state_e       state,
  output logic [LVL_W-1:0] target
);
  localparam logic [LVL_W-1:0] D1 = LVL_W'(1);
  localparam logic [LVL_W-1:0] D2 = LVL_W'(2);

  seq_state_e       nxt;
  logic [LVL_W-1:0] tgt_nxt;

  always_comb begin
    nxt     = state;
    tgt_nxt = target;
    unique case (state)
      ST_ACT: begin
        if (!wake && idle_req && idle_depth != '0) begin
          nxt     = ST_C1;
          tgt_nxt = idle_depth;
        end
      end
      ST_C1: begin
        if (wake) nxt = ST_ACT;
        else if (target > D1) nxt = ST_FLUSH;
        else if (idle_req && idle_depth > D1) begin
          nxt     = ST_FLUSH;
          tgt_nxt = idle_depth;
        end
      end
      ST_FLUSH: begin
        if (wake) nxt = ST_ACT;
        else if (flush_done) nxt = ST_C2;
      end
      ST_C2: begin
        if (wake) nxt = ST_UNGR;
        else if (target > D2) nxt = ST_SAVE;
        else if (idle_req && idle_depth > D2) begin
          nxt     = ST_SAVE;
          tgt_nxt = idle_depth;
        end
      end
      ST_SAVE: begin
        if (wake) nxt = ST_UNGR;
        else if (ctx_done) nxt = ST_C3;
      end
      ST_C3:      if (wake) nxt = ST_SETTLE;
      ST_SETTLE:  if (settle_done) nxt = ST_RESTORE;
      ST_RESTORE: if (ctx_done) nxt = ST_UNGR;
      ST_UNGR:    nxt = ST_ACT;
      default:    nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ACT;
      target <= '0;
    end else begin
      state  <= nxt;
      target <= tgt_nxt;
    end
  end

  // R8: a resting core never changes target without a request
  a_r8_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_req && state != ST_ACT) |=> $stable(target));

endmodule

// File: rtl/idle_seq_drive.sv
module idle_seq_drive
  import idle_seq_pkg::*;
(
  input  seq_state_e       state,
  input  logic [LVL_W-1:0] target,
  output drive_t           drv,
  output logic [LVL_W-1:0] level,
  output logic             busy
);
  always_comb begin
    drv   = '0;
    level = '0;
    busy  = 1'b1;
    unique case (state)
      ST_ACT: busy = 1'b0;
      ST_C1: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.snoop_en = 1'b1;
        level = LVL_W'(1);
        busy  = (target != LVL_W'(1));
      end
      ST_FLUSH: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.snoop_en = 1'b1;
        drv.flush_req = 1'b1;
        level = LVL_W'(1);
      end
      ST_C2: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.gate_rest = 1'b1;
        level = LVL_W'(2);
        busy  = (target != LVL_W'(2));
      end
      ST_SAVE: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.gate_rest = 1'b1;
        drv.save_req  = 1'b1;
        level = LVL_W'(2);
      end
      ST_C3: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.gate_rest = 1'b1;
        drv.pwr_off   = 1'b1;
        level = LVL_W'(3);
        busy  = 1'b0;
      end
      ST_SETTLE: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.gate_rest = 1'b1;
        level = LVL_W'(3);
      end
      ST_RESTORE: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.gate_rest = 1'b1;
        drv.restore_req = 1'b1;
        level = LVL_W'(3);
      end
      ST_UNGR: begin
        drv.pipe_stop = 1'b1; drv.gate_main = 1'b1; drv.snoop_en = 1'b1;
        level = LVL_W'(1);
      end
      default: busy = 1'b1;
    endcase
  end
endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic [1:0] idle_depth,
  input  logic       wake,
  input  logic       flush_done,
  input  logic       ctx_done,
  output logic       pipe_stop,
  output logic       clk_gate_main,
  output logic       clk_gate_rest,
  output logic       snoop_en,
  output logic       flush_req,
  output logic       save_req,
  output logic       restore_req,
  output logic       pwr_off,
  output logic [1:0] level,
  output logic       busy
);
  seq_state_e       state;
  logic [LVL_W-1:0] target;
  logic             settle_done;
  drive_t           drv;

  idle_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .idle_depth  (idle_depth),
    .wake        (wake),
    .flush_done  (flush_done),
    .ctx_done    (ctx_done),
    .settle_done (settle_done),
    .state       (state),
    .target      (target)
  );

  idle_seq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SETTLE),
    .done  (settle_done)
  );

  idle_seq_drive u_drive (
    .state  (state),
    .target (target),
    .drv    (drv),
    .level  (level),
    .busy   (busy)
  );

  assign pipe_stop     = drv.pipe_stop;
  assign clk_gate_main = drv.gate_main;
  assign clk_gate_rest = drv.gate_rest;
  assign snoop_en      = drv.snoop_en;
  assign flush_req     = drv.flush_req;
  assign save_req      = drv.save_req;
  assign restore_req   = drv.restore_req;
  assign pwr_off       = drv.pwr_off;

  // R11: snoops never run with the remaining clocks gated or the supply off
  a_r11_snoop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_en |-> (!clk_gate_rest && !pwr_off));

  // R4: the supply is only off with every clock gated and the pipe halted
  a_r4_off_needs_gates: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (clk_gate_rest && clk_gate_main && pipe_stop));

  // R3: remaining clocks get gated only right after a flush completion
  a_r3_rest_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_rest) |-> $past(flush_done));

  // R4: supply switches off only right after a save completion
  a_r4_off_after_save: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> $past(ctx_done));

  // R9: at most one handshake is open, and an open one means busy
  a_r9_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, save_req, restore_req}));
  a_r9_handshake_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req || save_req || restore_req) |-> busy);

  // R5: no restore while the supply is still off
  a_r5_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> !pwr_off);

endmodule

// File: tb/idle_seq_tb.sv
module idle_seq_tb;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0;
  logic [1:0] idle_depth = 2'd0;
  logic wake = 1'b0, flush_done = 1'b0, ctx_done = 1'b0;
  logic pipe_stop, clk_gate_main, clk_gate_rest, snoop_en;
  logic flush_req, save_req, restore_req, pwr_off, busy;
  logic [1:0] level;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  idle_seq #(.SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_depth(idle_depth),
    .wake(wake), .flush_done(flush_done), .ctx_done(ctx_done),
    .pipe_stop(pipe_stop), .clk_gate_main(clk_gate_main),
    .clk_gate_rest(clk_gate_rest), .snoop_en(snoop_en), .flush_req(flush_req),
    .save_req(save_req), .restore_req(restore_req), .pwr_off(pwr_off),
    .level(level), .busy(busy)
  );

  // Reference model: phase names as integers, driven from the requirements
  // 0 active, 1 rest L1, 2 flush wait, 3 rest L2, 4 save wait, 5 off,
  // 6 settle, 7 restore wait, 8 unwind step
  int m_ph = 0, m_tgt = 0, m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_tgt = 0; m_cnt = 0;
    end else begin
      int d;
      d = int'(idle_depth);
      case (m_ph)
        0: if (!wake && idle_req && d > 0) begin m_ph = 1; m_tgt = d; end
        1: if (wake) m_ph = 0;
           else if (m_tgt > 1) m_ph = 2;
           else if (idle_req && d > 1) begin m_ph = 2; m_tgt = d; end
        2: if (wake) m_ph = 0; else if (flush_done) m_ph = 3;
        3: if (wake) m_ph = 8;
           else if (m_tgt > 2) m_ph = 4;
           else if (idle_req && d > 2) begin m_ph = 4; m_tgt = d; end
        4: if (wake) m_ph = 8; else if (ctx_done) m_ph = 5;
        5: if (wake) begin m_ph = 6; m_cnt = 0; end
        6: begin
             if (m_cnt == S - 1) m_ph = 7;
             else m_cnt++;
           end
        7: if (ctx_done) m_ph = 8;
        default: m_ph = 0;
      endcase
    end
  end

  function automatic logic [10:0] model_out(int ph, int tgt);
    // {pipe_stop, gate_main, gate_rest, snoop, flush, save, restore, off, level[1:0], busy}
    case (ph)
      0: return 11'b0000_0000_00_0;
      1: return {8'b1101_0000, 2'd1, tgt != 1};
      2: return {8'b1101_1000, 2'd1, 1'b1};
      3: return {8'b1110_0000, 2'd2, tgt != 2};
      4: return {8'b1110_0100, 2'd2, 1'b1};
      5: return {8'b1110_0001, 2'd3, 1'b0};
      6: return {8'b1110_0000, 2'd3, 1'b1};
      7: return {8'b1110_0010, 2'd3, 1'b1};
      default: return {8'b1101_0000, 2'd1, 1'b1};
    endcase
  endfunction

  function automatic string ph_tag(int ph);
    case (ph)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6, 7: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [10:0] act, exp;
      act = {pipe_stop, clk_gate_main, clk_gate_rest, snoop_en, flush_req,
             save_req, restore_req, pwr_off, level, busy};
      exp = model_out(m_ph, m_tgt);
      n_tests++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s model phase %0d: actual %b expected %b", ph_tag(m_ph), m_ph, act, exp);
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // One-cycle request pulse
  task automatic req(int d);
    idle_req = 1'b1; idle_depth = 2'(d);
    tick();
    idle_req = 1'b0; idle_depth = 2'd0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(); wake = 1'b0;
  endtask

  task automatic pulse_flush();
    flush_done = 1'b1; tick(); flush_done = 1'b0;
  endtask

  task automatic pulse_ctx();
    ctx_done = 1'b1; tick(); ctx_done = 1'b0;
  endtask

  initial begin
    tick(3);
    chk("R1", level, 0, "level in reset");
    chk("R1", {pipe_stop, clk_gate_main, clk_gate_rest, pwr_off}, 0, "controls in reset");
    rst_n = 1'b1;
    tick();
    chk("R1", busy, 0, "busy after release");

    req(0);
    chk("R2", level, 0, "depth 0 ignored");

    req(1);
    chk("R2", {pipe_stop, clk_gate_main, snoop_en}, 7, "level 1 entry");
    chk("R11", snoop_en, 1, "snoop at level 1");
    flush_done = 1'b1; ctx_done = 1'b1; tick();
    flush_done = 1'b0; ctx_done = 1'b0;
    chk("R10", {flush_req, clk_gate_rest, level}, 1, "stray done at level 1");
    req(1);
    chk("R8", {level, busy}, 2, "equal depth ignored at rest");
    pulse_wake();
    chk("R6", {pipe_stop, level}, 0, "wake from level 1");

    wake = 1'b1; idle_req = 1'b1; idle_depth = 2'd2; tick();
    wake = 1'b0; idle_req = 1'b0; idle_depth = 2'd0;
    chk("R8", level, 0, "wake beats request");

    req(2);
    chk("R9", {level, busy}, 3, "level 1 passing through");
    tick();
    chk("R3", {flush_req, snoop_en}, 3, "flush wait keeps snoops");
    tick(2);
    chk("R3", clk_gate_rest, 0, "no gating before flush done");
    pulse_flush();
    chk("R3", {clk_gate_rest, snoop_en, level, busy}, 'b10100, "level 2 rest");
    pulse_ctx();
    chk("R10", {pwr_off, level}, 2, "stray ctx_done at level 2");
    pulse_wake();
    chk("R6", {clk_gate_rest, snoop_en, pipe_stop, level}, 'b01101, "level 2 unwind");
    tick();
    chk("R6", level, 0, "active after unwind");

    req(3); tick(); pulse_flush(); tick();
    chk("R4", {save_req, level}, 6, "save wait");
    tick(2);
    pulse_ctx();
    chk("R4", {pwr_off, level, busy}, 'b1110, "level 3");
    req(2);
    chk("R8", level, 3, "shallow request at level 3 ignored");
    pulse_wake();
    chk("R5", {pwr_off, restore_req}, 0, "supply back on");
    tick(S - 1);
    chk("R5", restore_req, 0, "settle not over");
    tick();
    chk("R5", restore_req, 1, "restore after settle");
    tick(2);
    chk("R5", restore_req, 1, "restore waits for done");
    pulse_ctx();
    chk("R5", {clk_gate_rest, pipe_stop, level}, 'b0101, "clocks back, pipe held");
    tick();
    chk("R5", {pipe_stop, level}, 0, "pipeline released");

    req(2); tick();
    pulse_wake();
    chk("R7", {flush_req, pipe_stop, level}, 0, "abort in flush");

    req(3); tick(); pulse_flush(); tick();
    pulse_wake();
    chk("R7", {save_req, clk_gate_rest, pipe_stop, pwr_off, level}, 'b001001, "abort in save");
    tick();
    chk("R7", level, 0, "active after save abort");

    req(1);
    req(3);
    chk("R8", {flush_req, busy}, 3, "deeper request from level 1");
    req(1);
    chk("R8", flush_req, 1, "request during transition ignored");
    pulse_flush(); tick(); pulse_ctx();
    chk("R9", {level, busy}, 6, "reached level 3");
    pulse_wake(); tick(S); pulse_ctx(); tick();

    req(2); tick(); pulse_flush();
    req(3);
    chk("R8", save_req, 1, "deeper request from level 2");
    pulse_wake(); tick();
    chk("R6", level, 0, "final active");

    tick(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule